// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the transmit output of a CAN protocol controller and the enable of the bus driver. It turns the controller's transmit level into a driver-dominant command and stops a transmit line that is stuck low from holding the bus dominant. The same gate shuts the driver while a thermal-shutdown or supply-undervoltage flag is raised.

The transmit line is asynchronous to the block clock and passes through a two-flop synchronizer. Every consecutive clock cycle in which the synchronized line is low is counted. When the count reaches `TIMEOUT_CYC`, the driver is disabled and a timeout flag is raised. A single rule re-arms the driver after a timeout, after a thermal fault and after an undervoltage fault: a rising edge on the synchronized transmit line, seen while neither fault flag is active. The timer keeps running during faults, because only the transmitter is shut down. A deasserted normal-mode flag holds the driver recessive and does not change the arm state.

Top module: `tx_dom_guard`

## Requirements
- R1: During and after reset, `drv_dom_o` is 0 and `timeout_o` is 0.
- R2: In normal mode, with no fault and the driver armed, `drv_dom_o` equals the inverse of `tx_data_i` delayed by two clock edges (transmit low = dominant = 1).
- R3: A synchronized low lasting `TIMEOUT_CYC` cycles sets `timeout_o` to 1 and drives `drv_dom_o` to 0. A low of `TIMEOUT_CYC-1` cycles leaves `timeout_o` at 0 and the driver dominant. `drv_dom_o` is never high while `timeout_o` is high.
- R4: After a timeout, a rising edge on the synchronized transmit line clears `timeout_o` and re-arms the driver. Without that edge both stay as they are.
- R5: While `therm_fault_i` is 1, `drv_dom_o` is 0. Once the flag clears, the driver stays off until a rising edge of the transmit line. This holds even when the fault came and went while the transmit line was high.
- R6: `uv_fault_i` has the same effect as `therm_fault_i`: the driver is off while it is set, and it is re-armed only by a later rising edge.
- R7: A rising edge that is acted on in a cycle where either fault flag is 1 does not re-arm the driver. The case of a fault rising in that same cycle is included: the block is then left disarmed.
- R8: When `normal_mode_i` is 0, `drv_dom_o` is 0 and the arm state is untouched. Raising the flag while the transmit line is low gives `drv_dom_o` = 1 on the next sample.
- R9: Faults do not stop the dominant timer. A low that lasts past the limit during a thermal fault still sets `timeout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 1 | Controller transmit level, asynchronous (0 = dominant) |
| therm_fault_i | input | 1 | Over-temperature flag, synchronous |
| uv_fault_i | input | 1 | Supply undervoltage flag, synchronous |
| normal_mode_i | input | 1 | 1 = normal mode, 0 = driver held recessive |
| drv_dom_o | output | 1 | Driver command, 1 = drive bus dominant |
| timeout_o | output | 1 | Dominant timeout has expired and is not yet cleared |

## Verification
Two events can fall on the same clock edge: the re-arming rising edge of the transmit line, and a fault flag that sets the disarm latch. The bench raises the thermal flag for exactly the cycle in which the synchronized rising edge is acted on. It then drives the line low and expects the driver to stay recessive, because setting the latch has priority over re-arming. A low of exactly `TIMEOUT_CYC` cycles also puts the timeout on the edge just before its own releasing rising edge. Random segments from a cycle-level reference model cover both collisions and many more.

// File: rtl/tdg_pkg.sv
package tdg_pkg;

  typedef struct packed {
    logic therm;
    logic uv;
  } fault_t;

  function automatic logic fault_any(fault_t f);
    return f.therm | f.uv;
  endfunction

endpackage

// File: rtl/tdg_sync.sv
module tdg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/tdg_rise_det.sv
module tdg_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign rise_o = ~prev_q & lvl_i;

endmodule

// File: rtl/tdg_dom_timer.sv
module tdg_dom_timer #(
  parameter int unsigned TIMEOUT_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_i,
  output logic tmo_set_o,
  output logic tmo_o
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic             tmo_q;

  // expiry fires on the edge that completes the TIMEOUT_CYC-th low cycle
  assign tmo_set_o = ~lvl_i & (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      if (lvl_i)                cnt_q <= '0;
      else if (cnt_q != CNT_FULL) cnt_q <= cnt_q + CNT_W'(1);
      if (tmo_set_o)            tmo_q <= 1'b1;
      else if (rise_i)          tmo_q <= 1'b0;
    end
  end

  assign tmo_o = tmo_q;

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);

  p_tmo_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_q && !rise_i) |=> tmo_q);

endmodule

// File: rtl/tdg_arm_ctrl.sv
module tdg_arm_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tmo_set_i,
  input  logic fault_i,
  input  logic rise_i,
  output logic blocked_o
);

  logic blocked_q;

  // disarm wins over re-arm when both land on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 blocked_q <= 1'b0;
    else if (tmo_set_i | fault_i) blocked_q <= 1'b1;
    else if (rise_i)             blocked_q <= 1'b0;
  end

  assign blocked_o = blocked_q;

  p_fault_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> blocked_q);

  p_rearm_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blocked_q) |-> ($past(rise_i) && !$past(fault_i)));

endmodule

// File: rtl/tx_dom_guard.sv
module tx_dom_guard
  import tdg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 5000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_data_i,
  input  logic therm_fault_i,
  input  logic uv_fault_i,
  input  logic normal_mode_i,
  output logic drv_dom_o,
  output logic timeout_o
);

  logic   tx_lvl;
  logic   tx_rise;
  logic   tmo_set;
  logic   blocked;
  logic   flt_any;
  fault_t flt;

  assign flt     = '{therm: therm_fault_i, uv: uv_fault_i};
  assign flt_any = fault_any(flt);

  tdg_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tx_data_i),
    .q_o    (tx_lvl)
  );

  tdg_rise_det i_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (tx_lvl),
    .rise_o (tx_rise)
  );

  tdg_dom_timer #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (tx_lvl),
    .rise_i    (tx_rise),
    .tmo_set_o (tmo_set),
    .tmo_o     (timeout_o)
  );

  tdg_arm_ctrl i_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tmo_set_i (tmo_set),
    .fault_i   (flt_any),
    .rise_i    (tx_rise),
    .blocked_o (blocked)
  );

  // live fault terms cut the driver before the latch catches up
  assign drv_dom_o = normal_mode_i & ~flt_any & ~blocked & ~tx_lvl;

  p_tmo_gates_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !drv_dom_o);

  p_mode_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !normal_mode_i |-> !drv_dom_o);

endmodule

// File: tb/test_tx_dom_guard.sv
`timescale 1ns/1ps
module test_tx_dom_guard;

  localparam int LIM = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx = 1'b1;
  logic therm = 1'b0;
  logic uv = 1'b0;
  logic normal = 1'b0;
  logic drv, tmo;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit chk_en = 1'b0;

  always #2 clk = ~clk;

  tx_dom_guard #(.TIMEOUT_CYC(LIM), .SYNC_STAGES(2)) i_tx_dom_guard (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tx_data_i     (tx),
    .therm_fault_i (therm),
    .uv_fault_i    (uv),
    .normal_mode_i (normal),
    .drv_dom_o     (drv),
    .timeout_o     (tmo)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle-level reference model built from the requirements
  logic m_s1, m_s2, m_prev, m_tmo, m_blk;
  int   m_low;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_prev = 1'b1;
      m_tmo = 1'b0; m_blk = 1'b0; m_low = 0;
    end else begin
      logic f, rise, tset;
      f    = therm | uv;
      rise = !m_prev && m_s2;
      tset = !m_s2 && (m_low == LIM - 1);
      if (tset) m_tmo = 1'b1; else if (rise) m_tmo = 1'b0;
      if (tset || f) m_blk = 1'b1; else if (rise) m_blk = 1'b0;
      if (m_s2) m_low = 0; else if (m_low != LIM) m_low = m_low + 1;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = tx;
    end
  end

  function automatic logic exp_drv();
    return normal & !therm & !uv & !m_blk & !m_s2;
  endfunction

  always @(posedge clk) begin
    #1;
    if (chk_en) begin
      chk("R2 model drv_dom", drv, exp_drv());
      chk("R3 model timeout", tmo, m_tmo);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    wait_n(3);
    chk("R1 reset drv", drv, 1'b0);
    chk("R1 reset timeout", tmo, 1'b0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    normal = 1'b1;
    wait_n(3);
    chk("R1 after reset drv", drv, 1'b0);

    // R2 latency
    tx = 1'b0;
    wait_n(1);
    chk("R2 one edge no change", drv, 1'b0);
    wait_n(1);
    chk("R2 dominant after two edges", drv, 1'b1);
    tx = 1'b1;
    wait_n(3);
    chk("R2 recessive", drv, 1'b0);

    // R3 just below the limit
    tx = 1'b0;
    wait_n(LIM - 1);
    chk("R3 below limit still dominant", drv, 1'b1);
    tx = 1'b1;
    wait_n(4);
    chk("R3 below limit no timeout", tmo, 1'b0);

    // R3 above the limit, R4 re-arm
    tx = 1'b0;
    wait_n(LIM + 5);
    chk("R3 timeout set", tmo, 1'b1);
    chk("R3 driver off", drv, 1'b0);
    tx = 1'b1;
    wait_n(3);
    chk("R4 timeout cleared by rise", tmo, 1'b0);
    tx = 1'b0;
    wait_n(2);
    chk("R4 re-armed", drv, 1'b1);
    tx = 1'b1;
    wait_n(3);

    // exact limit: timeout then immediate release
    tx = 1'b0;
    wait_n(LIM);
    tx = 1'b1;
    wait_n(4);
    chk("R4 exact limit released", tmo, 1'b0);

    // R5 thermal during dominant
    tx = 1'b0;
    wait_n(2);
    chk("R5 pre dominant", drv, 1'b1);
    therm = 1'b1;
    wait_n(1);
    chk("R5 thermal cuts driver", drv, 1'b0);
    chk("R9 thermal leaves timeout", tmo, 1'b0);
    therm = 1'b0;
    wait_n(1);
    chk("R5 stays off after clear", drv, 1'b0);
    tx = 1'b1;
    wait_n(3);
    tx = 1'b0;
    wait_n(2);
    chk("R5 re-armed by rise", drv, 1'b1);
    tx = 1'b1;
    wait_n(3);

    // R5 fault while line high still needs an edge
    therm = 1'b1;
    wait_n(1);
    therm = 1'b0;
    wait_n(1);
    tx = 1'b0;
    wait_n(2);
    chk("R5 no edge yet", drv, 1'b0);
    tx = 1'b1;
    wait_n(3);
    tx = 1'b0;
    wait_n(2);
    chk("R5 edge re-arms", drv, 1'b1);
    tx = 1'b1;
    wait_n(3);

    // R6 undervoltage
    tx = 1'b0;
    wait_n(2);
    uv = 1'b1;
    wait_n(1);
    chk("R6 uv cuts driver", drv, 1'b0);
    uv = 1'b0;
    wait_n(1);
    chk("R6 stays off after clear", drv, 1'b0);
    tx = 1'b1;
    wait_n(3);
    tx = 1'b0;
    wait_n(2);
    chk("R6 re-armed by rise", drv, 1'b1);
    tx = 1'b1;
    wait_n(3);

    // R7 rise during fault
    uv = 1'b1;
    tx = 1'b0;
    wait_n(2);
    tx = 1'b1;
    wait_n(3);
    uv = 1'b0;
    wait_n(1);
    tx = 1'b0;
    wait_n(2);
    chk("R7 rise under fault ignored", drv, 1'b0);
    tx = 1'b1;
    wait_n(3);
    tx = 1'b0;
    wait_n(2);
    chk("R7 clean rise re-arms", drv, 1'b1);

    // R7 fault rising on the re-arm edge
    tx = 1'b1;
    wait_n(2);
    therm = 1'b1;
    wait_n(1);
    therm = 1'b0;
    tx = 1'b0;
    wait_n(2);
    chk("R7 collision keeps disarmed", drv, 1'b0);
    tx = 1'b1;
    wait_n(3);
    tx = 1'b0;
    wait_n(2);
    chk("R7 later rise re-arms", drv, 1'b1);
    tx = 1'b1;
    wait_n(3);

    // R8 normal mode gate
    normal = 1'b0;
    tx = 1'b0;
    wait_n(2);
    chk("R8 idle mode recessive", drv, 1'b0);
    normal = 1'b1;
    wait_n(1);
    chk("R8 arm state kept", drv, 1'b1);
    tx = 1'b1;
    wait_n(3);

    // R9 timer runs under thermal fault
    therm = 1'b1;
    tx = 1'b0;
    wait_n(LIM + 3);
    chk("R9 timeout under fault", tmo, 1'b1);
    therm = 1'b0;
    tx = 1'b1;
    wait_n(3);
    chk("R9 timeout cleared", tmo, 1'b0);
    tx = 1'b0;
    wait_n(2);
    chk("R9 re-armed", drv, 1'b1);
    tx = 1'b1;
    wait_n(3);

    // random segments against the model
    for (int seg = 0; seg < 300; seg++) begin
      int len;
      len    = 1 + int'($urandom_range(LIM + 6));
      tx     = 1'($urandom_range(1));
      therm  = ($urandom_range(9) == 0);
      uv     = ($urandom_range(9) == 1);
      normal = ($urandom_range(15) != 0);
      for (int k = 0; k < len; k++) begin
        wait_n(1);
        if ($urandom_range(7) == 0) therm = 1'b0;
        if ($urandom_range(7) == 0) uv = 1'b0;
      end
    end

    wait_n(2);
    done = 1'b1;
    chk_en = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule